// File: doc/BRIEF.md
# Watermark-Flagged UART Transmitter

This block is the transmit half of an asynchronous serial port. Software pushes words into a small FIFO. A frame engine takes each word from the FIFO and sends it on a single line as a low start bit, the data bits least significant first, and one high stop bit. Every bit lasts sixteen ticks of an internal oversampling strobe, and that strobe is divided down from the system clock. Frames carry eight data bits, or nine when the ninth-bit mode is selected. In that case bit 8 of the written word goes out after bit 7.

The status output `tdre` tells software when it may refill the FIFO. The flag only changes when the engine takes a word from the FIFO. At that moment it rises if the number of words left in the FIFO is less than or equal to a programmable watermark. While a frame is in flight, the next word is taken at one fixed point: the ninth oversample tick of the current frame's stop bit. This lets the next frame follow with no idle gap. With the watermark at zero, a rising flag means the last queued word has moved into the shifter.

Dropping the enable and raising it again queues a preamble. A preamble is one frame time of constant high, and it goes out ahead of the next data. A write to a full FIFO is dropped and raises a sticky error bit.

Top module: `uart_tx_wm`

## Requirements
- R1: With the FIFO empty, no frame starts and `tx` stays high. A data frame starts only when at least one word is queued.
- R2: A data frame is one low start bit, then `wr_data[7:0]` least significant bit first, then one high stop bit. Each bit lasts 16 oversample ticks.
- R3: When `nine_bit` is 1, `wr_data[8]` is sent as a ninth data bit between bit 7 and the stop bit.
- R4: When a word is taken from the FIFO, `tdre` becomes 1 if the remaining count is less than or equal to `watermark`. A word is taken from an idle line on the next tick.
- R5: While a frame is running, the next word is taken at the 9th tick of its stop bit, and `tdre` is updated then. The next frame's start bit follows the stop bit with no gap.
- R6: `tdre` resets to 1. An accepted write that leaves the count above `watermark` clears it.
- R7: A write while the FIFO holds DEPTH words is ignored, meaning the word is never sent. It sets `wr_err`, which stays 1 until reset.
- R8: While `en` is 0, no new frame starts. A rising `en` queues a preamble, a full frame time of constant high (10 bit times in 8-bit mode), which goes out before the next data frame.
- R9: During reset, `tx` is 1, `tdre` is 1 and `wr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| nine_bit | input | 1 | 1 selects 9-bit data frames |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| watermark | input | $clog2(DEPTH+1) | Count threshold for `tdre` |
| tdre | output | 1 | Transmit-data-empty flag |
| wr_err | output | 1 | Sticky flag for a write to a full FIFO |
| tx | output | 1 | Serial output, high when idle |

## Verification
A wrong bit counter or tick counter first shows as a shifted or missing data bit in the serial capture. A corrupted load slot shows as `tdre` rising one or more cycles away from 153 clock cycles after a frame's start. It also shows as a gap, or a collision, between back-to-back frames within that same frame. A lost or extra FIFO word shows as a wrong data byte or an unexpected start bit within one frame time of the FIFO draining. A missed preamble shifts the next start bit by exactly 160 cycles.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int OVS      = 16;
   localparam int SUBW     = $clog2(OVS);
   localparam int LOAD_SUB = 8;
   localparam int FRW      = 11;

   typedef logic [FRW-1:0] frame_t;

   function automatic frame_t build_frame(input logic nine, input logic [8:0] d);
      return nine ? {1'b1, d, 1'b0} : {2'b11, d[7:0], 1'b0};
   endfunction
endpackage

// File: rtl/txw_tickgen.sv
module txw_tickgen #(
   parameter int DIV = 4,
   localparam int W  = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   logic [W-1:0] cnt;

   assign tick = (cnt == W'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/txw_fifo.sv
module txw_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 9,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          push_ok, pop_ok;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= step(wp);
         if (pop_ok)  rp <= step(rp);
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end
endmodule

// File: rtl/txw_shift.sv
module txw_shift
   import txw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       pre_req,
   input  logic       have_data,
   input  logic       nine,
   input  logic [8:0] head,
   output logic       pop,
   output logic       take_pre,
   output logic       busy,
   output logic       tx
);
   frame_t    sreg, nxt, newframe;
   logic      have_next, want, at_slot, start_idle, slot_load, load;
   logic [SUBW-1:0] sub;
   logic [3:0] bitcnt, last;

   assign last       = nine ? 4'd10 : 4'd9;
   assign want       = en & (pre_req | have_data);
   assign at_slot    = busy & (sub == SUBW'(LOAD_SUB)) & (bitcnt == last) & ~have_next;
   assign start_idle = tick & ~busy & want;
   assign slot_load  = tick & at_slot & want;
   assign load       = start_idle | slot_load;
   assign take_pre   = load & pre_req;
   assign pop        = load & ~pre_req;
   assign newframe   = pre_req ? '1 : build_frame(nine, head);
   assign tx         = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sub       <= '0;
         bitcnt    <= '0;
         sreg      <= '1;
         nxt       <= '1;
         have_next <= 1'b0;
      end else if (tick) begin
         if (!busy) begin
            if (want) begin
               sreg   <= newframe;
               busy   <= 1'b1;
               sub    <= '0;
               bitcnt <= '0;
            end
         end else begin
            sub <= sub + 1'b1;
            if (slot_load) begin
               nxt       <= newframe;
               have_next <= 1'b1;
            end
            if (sub == SUBW'(OVS - 1)) begin
               if (bitcnt == last) begin
                  if (have_next) begin
                     sreg      <= nxt;
                     have_next <= 1'b0;
                     bitcnt    <= '0;
                  end else begin
                     busy <= 1'b0;
                  end
               end else begin
                  sreg   <= {1'b1, sreg[FRW-1:1]};
                  bitcnt <= bitcnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/uart_tx_wm.sv
module uart_tx_wm #(
   parameter int DEPTH    = 4,
   parameter int TICK_DIV = 4,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          nine_bit,
   input  logic          wr_en,
   input  logic [8:0]    wr_data,
   input  logic [CW-1:0] watermark,
   output logic          tdre,
   output logic          wr_err,
   output logic          tx
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_tx_wm: DEPTH must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("uart_tx_wm: TICK_DIV must be at least 1");
      end
   endgenerate

   logic          tick, fifo_full, fifo_empty, pop, take_pre, busy;
   logic          en_q, pre_pend, pre_req, acc;
   logic [8:0]    head;
   logic [CW-1:0] fifo_cnt, cnt_next;

   assign acc      = wr_en & ~fifo_full;
   assign cnt_next = fifo_cnt + CW'(acc) - CW'(pop);
   assign pre_req  = pre_pend | (en & ~en_q);

   txw_tickgen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   txw_fifo #(.DEPTH(DEPTH), .W(9)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(pop), .din(wr_data),
      .dout(head), .cnt(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
   );

   txw_shift u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pre_req(pre_req),
      .have_data(~fifo_empty), .nine(nine_bit), .head(head), .pop(pop),
      .take_pre(take_pre), .busy(busy), .tx(tx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         pre_pend <= 1'b0;
         tdre     <= 1'b1;
         wr_err   <= 1'b0;
      end else begin
         en_q     <= en;
         pre_pend <= pre_req & ~take_pre;
         if (wr_en & fifo_full) wr_err <= 1'b1;
         if (pop)                                tdre <= (cnt_next <= watermark);
         else if (acc && (cnt_next > watermark)) tdre <= 1'b0;
      end
   end
endmodule

// File: rtl/txw_chk.sv
module txw_chk #(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          wr_en,
   input logic [CW-1:0] watermark,
   input logic          tdre,
   input logic          wr_err,
   input logic          tx,
   input logic [CW-1:0] cnt,
   input logic          full,
   input logic          busy,
   input logic          pop
);
   AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tx) && !$past(busy)) |-> ($past(cnt) != '0)); // R1
   AST_TDRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> $past(pop)); // R4
   AST_TDRE_WM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> (cnt <= $past(watermark))); // R4
   AST_TDRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdre) |-> (cnt > $past(watermark))); // R6
   AST_ERR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> wr_err); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R7
   AST_EN_LOW_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy); // R8
endmodule

bind uart_tx_wm txw_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .watermark(watermark),
   .tdre(tdre), .wr_err(wr_err), .tx(tx), .cnt(fifo_cnt), .full(fifo_full),
   .busy(busy), .pop(pop)
);

// File: tb/tb_uart_tx_wm.sv
`timescale 1ns/1ps
module tb_uart_tx_wm;
   localparam int DEPTH = 4;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk, rst_n, en, nine_bit, wr_en;
   logic [8:0] wr_data;
   logic [CW-1:0] watermark;
   logic tdre, wr_err, tx;
   int n_chk = 0, n_fail = 0;

   // {nine_bit, word}
   localparam logic [9:0] VEC [6] = '{10'h0A5, 10'h03C, 10'h0FF, 10'h3C3, 10'h200, 10'h355};

   uart_tx_wm #(.DEPTH(DEPTH), .TICK_DIV(1)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .nine_bit(nine_bit), .wr_en(wr_en),
      .wr_data(wr_data), .watermark(watermark), .tdre(tdre), .wr_err(wr_err), .tx(tx)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rx_frame(input bit nine, output logic [8:0] d, output bit stop_ok, output bit got);
      int t = 0;
      while (tx !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
      got = (t < 2000);
      d = '0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         repeat (16) @(negedge clk);
         d[i] = tx;
      end
      repeat (16) @(negedge clk);
      stop_ok = (tx === 1'b1);
   endtask

   task automatic expect_frame(input bit nine, input logic [8:0] exp, input string req);
      logic [8:0] d; bit s, g;
      rx_frame(nine, d, s, g);
      chk(g, req, "start bit seen", int'(g), 1);
      chk(d == exp, req, "frame data", int'(d), int'(exp));
      chk(s, "R2", "stop bit high", int'(s), 1);
   endtask

   task automatic quiet(input int n, input string req);
      bit low = 1'b0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (tx !== 1'b1) low = 1'b1; end
      chk(!low, req, "line stays high", int'(low), 0);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t;
      rst_n = 1'b0; en = 1'b0; nine_bit = 1'b0; wr_en = 1'b0; wr_data = '0; watermark = '0;
      repeat (3) @(negedge clk);
      chk(tx === 1'b1, "R9", "tx in reset", int'(tx), 1);
      chk(tdre === 1'b1, "R9", "tdre in reset", int'(tdre), 1);
      chk(wr_err === 1'b0, "R9", "wr_err in reset", int'(wr_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: disabled transmitter holds a queued word
      wr(9'h05A);
      quiet(300, "R8");
      // R8: rising enable sends a 10-bit-time preamble first
      en = 1'b1;
      t = 0;
      do begin @(negedge clk); t++; end while (tx === 1'b1 && t < 1000);
      chk(t == 161, "R8", "cycles to first start bit after enable", t, 161);
      expect_frame(1'b0, 9'h05A, "R2");
      repeat (16) @(negedge clk);
      // R1: empty FIFO keeps line idle
      quiet(200, "R1");
      chk(tdre === 1'b1, "R4", "tdre after drain", int'(tdre), 1);

      // table of frames, 8- and 9-bit (R2, R3)
      for (int k = 0; k < 6; k++) begin
         nine_bit = VEC[k][9];
         wr(VEC[k][8:0]);
         expect_frame(VEC[k][9], VEC[k][9] ? VEC[k][8:0] : {1'b0, VEC[k][7:0]},
                      VEC[k][9] ? "R3" : "R2");
         repeat (16) @(negedge clk);
      end
      nine_bit = 1'b0;

      // R5/R6 with watermark 0: back-to-back words
      watermark = '0;
      wr(9'h0C1);
      wr(9'h0D2);
      chk(tdre === 1'b0, "R6", "tdre cleared by write", int'(tdre), 0);
      repeat (152) @(negedge clk);
      chk(tdre === 1'b0, "R5", "tdre before stop-bit slot", int'(tdre), 0);
      @(negedge clk);
      chk(tdre === 1'b1, "R5", "tdre at 9th stop tick", int'(tdre), 1);
      t = 0;
      while (tx === 1'b1 && t < 100) begin @(negedge clk); t++; end
      chk(t == 7, "R5", "gap before next start", t, 7);
      expect_frame(1'b0, 9'h0D2, "R5");
      repeat (16) @(negedge clk);

      // R4/R6 with watermark 1
      watermark = CW'(1);
      wr(9'h011);
      wr(9'h022);
      chk(tdre === 1'b1, "R4", "tdre with remaining 1 <= watermark 1", int'(tdre), 1);
      wr(9'h033);
      chk(tdre === 1'b0, "R6", "tdre with count 2 > watermark 1", int'(tdre), 0);
      expect_frame(1'b0, 9'h011, "R4");
      expect_frame(1'b0, 9'h022, "R4");
      expect_frame(1'b0, 9'h033, "R4");
      repeat (16) @(negedge clk);

      // R7: overfill while disabled
      en = 1'b0;
      @(negedge clk);
      wr(9'h041); wr(9'h042); wr(9'h043); wr(9'h044);
      chk(wr_err === 1'b0, "R7", "wr_err before overflow", int'(wr_err), 0);
      wr(9'h099);
      chk(wr_err === 1'b1, "R7", "wr_err after overflow", int'(wr_err), 1);
      en = 1'b1;
      expect_frame(1'b0, 9'h041, "R7");
      expect_frame(1'b0, 9'h042, "R7");
      expect_frame(1'b0, 9'h043, "R7");
      expect_frame(1'b0, 9'h044, "R7");
      quiet(400, "R7");
      chk(wr_err === 1'b1, "R7", "wr_err sticky", int'(wr_err), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule